// File: doc/BRIEF.md
# Virtual Channel Capability Register File

This block holds the extended configuration words that describe and steer the virtual channels of one link port. Software reads and writes them through a plain 32-bit register port addressed by dword index. The block exports the decoded control fields to the traffic steering and channel arbitration logic: the scheme select, and for each channel resource its class map, port arbitration select, channel ID and enable. The capability words are fixed by parameters and cannot be written.

The block also runs the table-load handshakes. A write of 1 to a load command bit raises the matching coherency status bit and a request output. The status bit stays set until the arbitration logic reports with a done input that the table has been applied. Enabling a resource marks channel negotiation as pending until a negotiation-done input arrives. The scheme select cannot be changed while more than one channel of the low-priority group is enabled. The low-priority group is channel 0 plus resources 1..`LP_EXT`.

Top module: `chcap_regfile`

## Requirements
- R1: The word at byte offset 00h reads 32'h0001_0002. This is the ID 0002h in [15:0], version 1 in [19:16] and the parameter `NEXT_PTR` in [31:20]. Writes to it have no effect.
- R2: Offset 04h reads `NUM_RES`-1 in [2:0], `LP_EXT` in [6:4], `REF_CLK` in [9:8] and `ENTRY_SIZE` in [11:10], which is 32'h0000_0413 with the defaults. Offset 08h reads `ARB_CAP` in [7:0] and `ARB_TBL_OFS` in [31:24], which is 32'h0600_0003 with the defaults.
- R3: A write to offset 0Ch stores [3:1] as the scheme select. The select reads back in [3:1] and drives `arb_sel` from the next cycle. Bit 0 always reads 0.
- R4: A write to 0Ch with bit 0 set raises the port table status (read at bit 16 of the 0Ch word, the 0Eh half) and `vc_tbl_pend`. A `vc_tbl_done` pulse clears both. If a load write and a done arrive in the same cycle, the status stays set.
- R5: Writes to the scheme select are ignored while more than one channel in the low-priority group (channel 0 and resources 1..`LP_EXT`) is enabled. Other resources do not take part in this rule.
- R6: The resource N control word at 14h+N*0Ch stores the class map [7:0], port select [19:17], channel ID [26:24] and enable [31], and exports them on the channel outputs. Load bit [16] always reads 0.
- R7: Writing 1 to bit 16 of a resource control word sets bit 0 of that resource's status word at 18h+N*0Ch and the matching `port_tbl_pend` bit. The matching `port_tbl_done` bit clears them, and a load in the same cycle wins.
- R8: Negotiation pending (status bit 1) sets when a write changes a resource's enable from 0 to 1, and clears on the matching `neg_done` bit. A write that keeps the enable at 1 leaves it unchanged.
- R9: Resource 0 always reads and exports enable 1 and ID 0. Its negotiation pending never sets.
- R10: Reserved bits read 0 and ignore writes. Dword indexes past the last resource read 0. Status and capability words ignore writes.
- R11: Every resource capability word at 10h+N*0Ch reads `PORT_ARB_CAP` in [7:0], `MAX_SLOTS` in [22:16] and `PAT_OFS` in [31:24], which is 32'h001F_0001 with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_word | input | 10 | Dword index (byte offset / 4) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_word`, combinational |
| vc_tbl_done | input | 1 | Port arbitration table has been applied |
| port_tbl_done | input | NUM_RES | Per-resource port table has been applied |
| neg_done | input | NUM_RES | Per-resource negotiation finished |
| arb_sel | output | 3 | Channel arbitration scheme select |
| vc_tbl_pend | output | 1 | Port table load pending |
| ch_enable | output | NUM_RES | Resource enables |
| ch_class_map | output | 8*NUM_RES | Class maps, resource N at [8N+7:8N] |
| ch_id | output | 3*NUM_RES | Channel IDs, resource N at [3N+2:3N] |
| ch_port_sel | output | 3*NUM_RES | Port arbitration selects |
| port_tbl_pend | output | NUM_RES | Per-resource port table load pending |
| neg_pend | output | NUM_RES | Per-resource negotiation pending |

## Verification
Read data depends only on the current index and stored state, so a read is due in the same cycle the index is applied. A write or a done pulse takes effect at the first rising edge on which it is sampled. Its result appears on the read port and the exported outputs right after that edge. The bench drives every input at the falling edge and holds it across one rising edge. It samples one time unit after the next falling edge, where every result of that edge has settled and no edge is near. The same-cycle cases (load with done, write while locked) are driven together in one cycle so that the priority is observed directly.

// File: rtl/chcap_pkg.sv
package chcap_pkg;
    localparam logic [15:0] CAP_ID  = 16'h0002;
    localparam logic [3:0]  CAP_VER = 4'h1;
    localparam int          WORD_W  = 10;
    // writable bits of a resource control word: enable, ID, port select, map
    localparam logic [31:0] RES_WMASK  = 32'h870E_00FF;
    localparam logic [31:0] RES0_WMASK = 32'h000E_00FF;
    localparam int          RES_LOAD_BIT = 16;
    localparam int          RES_EN_BIT   = 31;

    typedef struct packed {
        logic [2:0] sel;
        logic       tbl_pend;
    } port_state_t;

    typedef struct packed {
        logic [31:0] ctl;
        logic        ptbl_pend;
        logic        neg_pend;
    } res_state_t;
endpackage

// File: rtl/chcap_port.sv
module chcap_port
    import chcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctl,
    input  logic [3:0] wdata,
    input  logic       locked,
    input  logic       tbl_done,
    output logic [2:0] arb_sel,
    output logic       tbl_pend
);
    port_state_t q, d;

    always_comb begin
        d = q;
        if (tbl_done) d.tbl_pend = 1'b0;
        if (wr_ctl) begin
            if (!locked) d.sel = wdata[3:1];
            if (wdata[0]) d.tbl_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign arb_sel  = q.sel;
    assign tbl_pend = q.tbl_pend;

    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && locked) |=> (arb_sel == $past(arb_sel))); // R5
    AST_TBL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[0]) |=> tbl_pend); // R4
    AST_TBL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_done && !(wr_ctl && wdata[0])) |=> !tbl_pend); // R4
endmodule

// File: rtl/chcap_res.sv
module chcap_res
    import chcap_pkg::*;
#(
    parameter bit FIXED0 = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctl,
    input  logic [31:0] wdata,
    input  logic        ptbl_done,
    input  logic        neg_done,
    output logic [31:0] ctl_word,
    output logic [1:0]  status,
    output logic        ptbl_pend,
    output logic        neg_pend
);
    localparam logic [31:0] WMASK   = FIXED0 ? RES0_WMASK : RES_WMASK;
    localparam logic [31:0] FORCED  = FIXED0 ? 32'h8000_0000 : 32'h0;

    res_state_t q, d;
    logic en_rise;

    always_comb begin
        d = q;
        en_rise = wr_ctl && wdata[RES_EN_BIT] && !q.ctl[RES_EN_BIT];
        if (ptbl_done) d.ptbl_pend = 1'b0;
        if (neg_done)  d.neg_pend  = 1'b0;
        if (wr_ctl) begin
            d.ctl = (wdata & WMASK) | FORCED;
            if (wdata[RES_LOAD_BIT]) d.ptbl_pend = 1'b1;
            if (en_rise)             d.neg_pend  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.ctl <= FORCED;
        end else begin
            q <= d;
        end
    end

    assign ctl_word  = q.ctl;
    assign ptbl_pend = q.ptbl_pend;
    assign neg_pend  = q.neg_pend;
    assign status    = {q.neg_pend, q.ptbl_pend};

    AST_PTBL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[RES_LOAD_BIT]) |=> ptbl_pend); // R7
    AST_NEG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[RES_EN_BIT] && !ctl_word[RES_EN_BIT]) |=> neg_pend); // R8
    AST_NEG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_done && !(wr_ctl && wdata[RES_EN_BIT] && !ctl_word[RES_EN_BIT]))
        |=> !neg_pend); // R8
    AST_LOAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> !ctl_word[RES_LOAD_BIT]); // R6
endmodule

// File: rtl/chcap_regfile.sv
module chcap_regfile
    import chcap_pkg::*;
#(
    parameter int          NUM_RES      = 4,
    parameter int          LP_EXT       = 1,
    parameter logic [1:0]  REF_CLK      = 2'd0,
    parameter logic [1:0]  ENTRY_SIZE   = 2'd1,
    parameter logic [7:0]  ARB_CAP      = 8'h03,
    parameter logic [7:0]  ARB_TBL_OFS  = 8'h06,
    parameter logic [11:0] NEXT_PTR     = 12'h000,
    parameter logic [7:0]  PORT_ARB_CAP = 8'h01,
    parameter logic [6:0]  MAX_SLOTS    = 7'h1F,
    parameter logic [7:0]  PAT_OFS      = 8'h00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [9:0]             reg_word,
    input  logic                   reg_wr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   vc_tbl_done,
    input  logic [NUM_RES-1:0]     port_tbl_done,
    input  logic [NUM_RES-1:0]     neg_done,
    output logic [2:0]             arb_sel,
    output logic                   vc_tbl_pend,
    output logic [NUM_RES-1:0]     ch_enable,
    output logic [8*NUM_RES-1:0]   ch_class_map,
    output logic [3*NUM_RES-1:0]   ch_id,
    output logic [3*NUM_RES-1:0]   ch_port_sel,
    output logic [NUM_RES-1:0]     port_tbl_pend,
    output logic [NUM_RES-1:0]     neg_pend
);
    localparam logic [2:0]  EXTRA   = 3'(NUM_RES - 1);
    localparam logic [2:0]  LP_CNT  = 3'(LP_EXT);
    localparam logic [31:0] HDR_W   = {NEXT_PTR, CAP_VER, CAP_ID};
    localparam logic [31:0] CAP1_W  = {20'h0, ENTRY_SIZE, REF_CLK, 1'b0, LP_CNT, 1'b0, EXTRA};
    localparam logic [31:0] CAP2_W  = {ARB_TBL_OFS, 16'h0, ARB_CAP};
    localparam logic [31:0] RCAP_W  = {PAT_OFS, 1'b0, MAX_SLOTS, 8'h0, PORT_ARB_CAP};

    logic [31:0] res_ctl  [NUM_RES];
    logic [1:0]  res_stat [NUM_RES];
    logic        locked;

    assign locked = $countones(ch_enable[LP_EXT:0]) > 1;

    chcap_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (reg_wr && (reg_word == 10'd3)),
        .wdata    (reg_wdata[3:0]),
        .locked   (locked),
        .tbl_done (vc_tbl_done),
        .arb_sel  (arb_sel),
        .tbl_pend (vc_tbl_pend)
    );

    for (genvar n = 0; n < NUM_RES; n++) begin : g_res
        localparam logic [9:0] CTL_IDX = 10'(5 + 3*n);
        chcap_res #(.FIXED0(n == 0)) u_res (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctl    (reg_wr && (reg_word == CTL_IDX)),
            .wdata     (reg_wdata),
            .ptbl_done (port_tbl_done[n]),
            .neg_done  (neg_done[n]),
            .ctl_word  (res_ctl[n]),
            .status    (res_stat[n]),
            .ptbl_pend (port_tbl_pend[n]),
            .neg_pend  (neg_pend[n])
        );
        assign ch_enable[n]          = res_ctl[n][31];
        assign ch_id[3*n +: 3]       = res_ctl[n][26:24];
        assign ch_port_sel[3*n +: 3] = res_ctl[n][19:17];
        assign ch_class_map[8*n +: 8] = res_ctl[n][7:0];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_word)
            10'd0: reg_rdata = HDR_W;
            10'd1: reg_rdata = CAP1_W;
            10'd2: reg_rdata = CAP2_W;
            10'd3: reg_rdata = {15'h0, vc_tbl_pend, 12'h0, arb_sel, 1'b0};
            default: ;
        endcase
        for (int n = 0; n < NUM_RES; n++) begin
            if (reg_word == 10'(4 + 3*n)) reg_rdata = RCAP_W;
            if (reg_word == 10'(5 + 3*n)) reg_rdata = res_ctl[n];
            if (reg_word == 10'(6 + 3*n)) reg_rdata = {30'h0, res_stat[n]};
        end
    end

    AST_CH0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word == 10'd5) |=> (ch_enable[0] && ch_id[2:0] == 3'd0)); // R9
endmodule

// File: tb/chcap_regfile_bench.sv
module chcap_regfile_bench;
    localparam int NR = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [9:0]      reg_word = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            vc_tbl_done = 1'b0;
    logic [NR-1:0]   port_tbl_done = '0;
    logic [NR-1:0]   neg_done = '0;
    logic [2:0]      arb_sel;
    logic            vc_tbl_pend;
    logic [NR-1:0]   ch_enable;
    logic [8*NR-1:0] ch_class_map;
    logic [3*NR-1:0] ch_id;
    logic [3*NR-1:0] ch_port_sel;
    logic [NR-1:0]   port_tbl_pend;
    logic [NR-1:0]   neg_pend;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    chcap_regfile u_chcap_regfile (
        .clk(clk), .rst_n(rst_n), .reg_word(reg_word), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vc_tbl_done(vc_tbl_done),
        .port_tbl_done(port_tbl_done), .neg_done(neg_done), .arb_sel(arb_sel),
        .vc_tbl_pend(vc_tbl_pend), .ch_enable(ch_enable), .ch_class_map(ch_class_map),
        .ch_id(ch_id), .ch_port_sel(ch_port_sel), .port_tbl_pend(port_tbl_pend),
        .neg_pend(neg_pend)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] w, input logic [31:0] d);
        @(negedge clk);
        reg_word = w; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [9:0] w, input logic [31:0] exp);
        reg_word = w;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic t_reset;
        rd_check("R1 header", 10'd0, 32'h0001_0002);
        rd_check("R2 cap word 1", 10'd1, 32'h0000_0413);
        rd_check("R2 cap word 2", 10'd2, 32'h0600_0003);
        rd_check("R11 res0 cap", 10'd4, 32'h001F_0001);
        rd_check("R11 res3 cap", 10'd13, 32'h001F_0001);
        rd_check("R4 port ctl/status reset", 10'd3, 32'h0);
        rd_check("R9 res0 ctl reset", 10'd5, 32'h8000_0000);
        rd_check("R6 res2 ctl reset", 10'd11, 32'h0);
        check("R3 arb_sel reset", 32'(arb_sel), 32'd0);
    endtask

    task automatic t_port_ctl;
        wr(10'd3, 32'hFFFF_FFF6);
        rd_check("R3 R10 select readback", 10'd3, 32'h0000_0006);
        check("R3 arb_sel", 32'(arb_sel), 32'd3);
        wr(10'd0, 32'hFFFF_FFFF);
        rd_check("R10 header ignores write", 10'd0, 32'h0001_0002);
        wr(10'd2, 32'h0);
        rd_check("R10 cap2 ignores write", 10'd2, 32'h0600_0003);
        rd_check("R10 unmapped index", 10'd16, 32'h0);
    endtask

    task automatic t_port_load;
        wr(10'd3, 32'h7);
        rd_check("R4 load sets status, R3 load reads 0", 10'd3, 32'h0001_0006);
        check("R4 vc_tbl_pend set", 32'(vc_tbl_pend), 32'd1);
        @(negedge clk); vc_tbl_done = 1'b1;
        @(negedge clk); vc_tbl_done = 1'b0;
        rd_check("R4 done clears status", 10'd3, 32'h0000_0006);
        check("R4 vc_tbl_pend clear", 32'(vc_tbl_pend), 32'd0);
        wr(10'd3, 32'h7);
        @(negedge clk);
        vc_tbl_done = 1'b1; reg_word = 10'd3; reg_wdata = 32'h7; reg_wr = 1'b1;
        @(negedge clk);
        vc_tbl_done = 1'b0; reg_wr = 1'b0;
        check("R4 load wins over done", 32'(vc_tbl_pend), 32'd1);
        @(negedge clk); vc_tbl_done = 1'b1;
        @(negedge clk); vc_tbl_done = 1'b0;
        check("R4 final clear", 32'(vc_tbl_pend), 32'd0);
    endtask

    task automatic t_lock;
        wr(10'd11, 32'h8000_0000);
        wr(10'd3, 32'h0000_000A);
        check("R5 non-group enable does not lock", 32'(arb_sel), 32'd5);
        wr(10'd8, 32'h8000_0000);
        wr(10'd3, 32'h0000_0004);
        check("R5 select ignored while locked", 32'(arb_sel), 32'd5);
        rd_check("R5 readback while locked", 10'd3, 32'h0000_000A);
        wr(10'd8, 32'h0);
        wr(10'd3, 32'h0000_0004);
        check("R5 select accepted after unlock", 32'(arb_sel), 32'd2);
    endtask

    task automatic t_res_ctl;
        wr(10'd14, 32'hFFFF_FFFF);
        rd_check("R6 R10 res3 ctl readback", 10'd14, 32'h870E_00FF);
        check("R6 class map out", 32'(ch_class_map[31:24]), 32'hFF);
        check("R6 id out", 32'(ch_id[11:9]), 32'd7);
        check("R6 port sel out", 32'(ch_port_sel[11:9]), 32'd7);
        check("R6 enable out", 32'(ch_enable[3]), 32'd1);
        rd_check("R7 R8 res3 status set", 10'd15, 32'h3);
        @(negedge clk); port_tbl_done[3] = 1'b1;
        @(negedge clk); port_tbl_done[3] = 1'b0;
        rd_check("R7 port table done clears", 10'd15, 32'h2);
        check("R7 port_tbl_pend clear", 32'(port_tbl_pend[3]), 32'd0);
        @(negedge clk); neg_done[3] = 1'b1;
        @(negedge clk); neg_done[3] = 1'b0;
        rd_check("R8 negotiation done clears", 10'd15, 32'h0);
        wr(10'd14, 32'h8000_00AA);
        check("R8 no re-rise while enabled", 32'(neg_pend[3]), 32'd0);
        check("R6 new class map", 32'(ch_class_map[31:24]), 32'hAA);
        wr(10'd14, 32'h0);
        wr(10'd14, 32'h8000_0000);
        check("R8 re-enable sets pending", 32'(neg_pend[3]), 32'd1);
        wr(10'd15, 32'h0);
        rd_check("R10 status ignores write", 10'd15, 32'h2);
    endtask

    task automatic t_ch0;
        wr(10'd5, 32'hFFFF_FFFF);
        rd_check("R9 res0 ctl forced", 10'd5, 32'h800E_00FF);
        check("R9 res0 enable", 32'(ch_enable[0]), 32'd1);
        check("R9 res0 id", 32'(ch_id[2:0]), 32'd0);
        rd_check("R9 R7 res0 status", 10'd6, 32'h1);
        wr(10'd5, 32'h0);
        check("R9 res0 stays enabled", 32'(ch_enable[0]), 32'd1);
    endtask

    initial begin
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_port_ctl();
        t_port_load();
        t_lock();
        t_res_ctl();
        t_ch0();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule